// File: doc/BRIEF.md
# Host-Controller Command and Status Registers

This block holds the 16-bit command register and the 16-bit status register in the configuration space of an embedded USB host controller. The two registers share one 32-bit configuration dword: the command register fills bytes 0 and 1, and the status register fills bytes 2 and 3. Software reaches them over a simple register bus. The bus carries a dword address, four byte enables, write data, a write strobe and a read-data return. Each write touches only the bytes whose enable is set.

The controller reports two kinds of event to the block as single-cycle pulses. One is a parity error on its internal interface. The other is a non-successful completion for a memory read that the controller started. The block keeps two write-one-to-clear status flags for these events. It also raises an internal system-error pulse when the event is qualified by the command register's enables. One command bit is brought out as a memory-space enable, which gates access to the controller's memory-mapped registers.

Top module: `hc_cfg_cmdstat`

## Requirements
- R1: After reset the dword reads 0290_0000h (command 0000h, status 0290h), and `mem_space_en` and `serr_int` are 0.
- R2: Only command bits 1 (memory enable), 6 (parity response) and 8 (system-error enable) can be written. Bits 1 and 6 are updated only when byte enable 0 is set, and bit 8 only when byte enable 1 is set.
- R3: Every other command bit reads 0 and ignores writes, and this includes bit 0.
- R4: `mem_space_en` always equals command bit 1.
- R5: Status bit 15 (parity flag) is set on the edge that samples `par_err_evt`, whatever the command bits hold.
- R6: A parity event sampled while command bits 6 and 8 are both 1 gives a `serr_int` pulse of exactly one cycle, starting in the cycle after the event.
- R7: A read-abort event sampled while `abort_serr_en` and command bit 8 are both 1 gives the same one-cycle `serr_int` pulse.
- R8: Status bit 14 (system-error flag) is set exactly when `serr_int` rises for an event. Neither of them can occur while command bit 8 is 0.
- R9: A write with byte enable 3 set clears status bit 15 or bit 14 wherever the write data holds 1 in that bit (data bits 31 and 30). A 0 in the data, or byte enable 3 being clear, leaves the bit as it was.
- R10: If a set event and a clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Status bits 0 to 13 always read the reset pattern 0290h and ignore writes.
- R12: A read at any dword address other than 1 returns 0, and a write there changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr | input | ADDR_W | Dword address; the registers sit at dword 1 |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rdata | output | 32 | Read data for the addressed dword (combinational) |
| par_err_evt | input | 1 | Pulse: internal-interface parity error |
| rd_abort_evt | input | 1 | Pulse: non-successful completion of a controller memory read |
| abort_serr_en | input | 1 | Lets read aborts raise the system error |
| mem_space_en | output | 1 | Memory-space enable for the controller's mapped registers |
| serr_int | output | 1 | Internal system-error pulse |

## Verification
The following properties are checked on every cycle by assertions:
- A system-error pulse is never produced unless the system-error enable was set.
- Every qualified parity event is followed by a pulse.
- Both flags set on the edge that samples their event.
- Command bits do not move when there is no write.
- Reserved command bits do not move even under a write.
- A clear with no competing set drops the flag.

The bench scenarios are needed for the rest. Only they show the exact byte-lane masking of the writable command bits, and that the read-back pattern is the fixed one. They also show the set-over-clear collision, the gating by `abort_serr_en`, and the silence of the other addresses, all compared against an independent model.

// File: rtl/hccs_pkg.sv
package hccs_pkg;

    localparam int REG_W = 16;

    // Command register layout
    localparam logic [REG_W-1:0] CMD_RST     = 16'h0000;
    localparam logic [REG_W-1:0] CMD_RW_MASK = 16'h0142;
    localparam int CMD_MEM  = 1;
    localparam int CMD_PRSP = 6;
    localparam int CMD_SEEN = 8;

    // Status register layout
    localparam logic [REG_W-1:0] STAT_RST      = 16'h0290;
    localparam logic [REG_W-1:0] STAT_W1C_MASK = 16'hC000;
    localparam int ST_PERR = 15;
    localparam int ST_SERR = 14;

    // One 16-bit half of a dword write
    typedef struct packed {
        logic             hit;
        logic [1:0]       be;
        logic [REG_W-1:0] data;
    } half_wr_t;

    // Event pulses from the controller
    typedef struct packed {
        logic par_err;
        logic rd_abort;
    } ev_t;

    function automatic logic [REG_W-1:0] lane_mask(input logic [1:0] be);
        return {{8{be[1]}}, {8{be[0]}}};
    endfunction

    function automatic logic [REG_W-1:0] lane_write(input logic [REG_W-1:0] cur,
                                                    input logic [REG_W-1:0] wd,
                                                    input logic [REG_W-1:0] mask,
                                                    input logic [1:0]       be);
        logic [REG_W-1:0] m;
        m = lane_mask(be) & mask;
        return (cur & ~m) | (wd & m);
    endfunction

    function automatic logic [REG_W-1:0] w1c_bits(input half_wr_t w,
                                                  input logic [REG_W-1:0] mask);
        return w.hit ? (w.data & mask & lane_mask(w.be)) : '0;
    endfunction

endpackage

// File: rtl/hccs_cmd_reg.sv
module hccs_cmd_reg
    import hccs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  half_wr_t         wr_i,
    output logic [REG_W-1:0] cmd_o
);

    logic [REG_W-1:0] cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_RST;
        end else if (wr_i.hit) begin
            cmd_q <= lane_write(cmd_q, wr_i.data, CMD_RW_MASK, wr_i.be);
        end
    end

    assign cmd_o = cmd_q;

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i.hit |=> $stable(cmd_q)); // R2

    AST_CMD_RSVD: assert property (@(posedge clk) disable iff (rst)
        wr_i.hit |=> ((cmd_q & ~CMD_RW_MASK) == ($past(cmd_q) & ~CMD_RW_MASK))); // R3

endmodule

// File: rtl/hccs_err_qual.sv
module hccs_err_qual
    import hccs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  ev_t              ev_i,
    input  logic [REG_W-1:0] cmd_i,
    input  logic             abort_en_i,
    output logic             fire_o,
    output logic             serr_o
);

    logic par_q_ok;
    logic abt_ok;
    logic serr_q;

    assign par_q_ok = ev_i.par_err  & cmd_i[CMD_PRSP];
    assign abt_ok   = ev_i.rd_abort & abort_en_i;
    assign fire_o   = cmd_i[CMD_SEEN] & (par_q_ok | abt_ok);

    always_ff @(posedge clk) begin
        if (rst) serr_q <= 1'b0;
        else     serr_q <= fire_o;
    end

    assign serr_o = serr_q;

    AST_SERR_GATED: assert property (@(posedge clk) disable iff (rst)
        serr_q |-> $past(cmd_i[CMD_SEEN])); // R8

    AST_SERR_PAR: assert property (@(posedge clk) disable iff (rst)
        (ev_i.par_err && cmd_i[CMD_PRSP] && cmd_i[CMD_SEEN]) |=> serr_q); // R6

    AST_SERR_ABT: assert property (@(posedge clk) disable iff (rst)
        (ev_i.rd_abort && abort_en_i && cmd_i[CMD_SEEN]) |=> serr_q); // R7

endmodule

// File: rtl/hccs_stat_reg.sv
module hccs_stat_reg
    import hccs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  half_wr_t         wr_i,
    input  logic             perr_set_i,
    input  logic             serr_set_i,
    output logic [REG_W-1:0] stat_o
);

    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] stat_q;

    always_comb begin
        set_vec          = '0;
        set_vec[ST_PERR] = perr_set_i;
        set_vec[ST_SERR] = serr_set_i;
    end

    assign clr_vec = w1c_bits(wr_i, STAT_W1C_MASK);

    for (genvar i = 0; i < REG_W; i++) begin : g_bit
        if (STAT_W1C_MASK[i]) begin : g_w1c
            always_ff @(posedge clk) begin
                if (rst) stat_q[i] <= STAT_RST[i];
                else     stat_q[i] <= set_vec[i] | (stat_q[i] & ~clr_vec[i]);
            end
        end else begin : g_ro
            assign stat_q[i] = STAT_RST[i];
        end
    end

    assign stat_o = stat_q;

    AST_PERR_SET: assert property (@(posedge clk) disable iff (rst)
        perr_set_i |=> stat_q[ST_PERR]); // R5

    AST_SERR_SET: assert property (@(posedge clk) disable iff (rst)
        serr_set_i |=> stat_q[ST_SERR]); // R10

    AST_PERR_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[ST_PERR] && !perr_set_i) |=> !stat_q[ST_PERR]); // R9

    AST_SERR_CLR: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[ST_SERR] && !serr_set_i) |=> !stat_q[ST_SERR]); // R9

endmodule

// File: rtl/hc_cfg_cmdstat.sv
module hc_cfg_cmdstat
    import hccs_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int REG_DW  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    input  logic              cfg_wr,
    output logic [31:0]       cfg_rdata,
    input  logic              par_err_evt,
    input  logic              rd_abort_evt,
    input  logic              abort_serr_en,
    output logic              mem_space_en,
    output logic              serr_int
);

    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_DW);

    logic             sel;
    half_wr_t         cmd_wr;
    half_wr_t         stat_wr;
    ev_t              ev;
    logic [REG_W-1:0] cmd;
    logic [REG_W-1:0] stat;
    logic             fire;

    assign sel     = (cfg_addr == MY_ADDR);
    assign cmd_wr  = '{hit: cfg_wr & sel, be: cfg_be[1:0], data: cfg_wdata[15:0]};
    assign stat_wr = '{hit: cfg_wr & sel, be: cfg_be[3:2], data: cfg_wdata[31:16]};
    assign ev      = '{par_err: par_err_evt, rd_abort: rd_abort_evt};

    hccs_cmd_reg u_cmd (
        .clk   (clk),
        .rst   (rst),
        .wr_i  (cmd_wr),
        .cmd_o (cmd)
    );

    hccs_err_qual u_qual (
        .clk        (clk),
        .rst        (rst),
        .ev_i       (ev),
        .cmd_i      (cmd),
        .abort_en_i (abort_serr_en),
        .fire_o     (fire),
        .serr_o     (serr_int)
    );

    hccs_stat_reg u_stat (
        .clk        (clk),
        .rst        (rst),
        .wr_i       (stat_wr),
        .perr_set_i (par_err_evt),
        .serr_set_i (fire),
        .stat_o     (stat)
    );

    assign mem_space_en = cmd[CMD_MEM];
    assign cfg_rdata    = sel ? {stat, cmd} : 32'h0;

    AST_MISS_NOWR: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !sel) |=> $stable(mem_space_en)); // R12

    AST_SERR_FLAG: assert property (@(posedge clk) disable iff (rst)
        serr_int |-> stat[ST_SERR]); // R8

endmodule

// File: tb/tb_hc_cfg_cmdstat.sv
`timescale 1ns/1ps
module tb_hc_cfg_cmdstat;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_be;
    logic [31:0] cfg_wdata;
    logic        cfg_wr;
    logic [31:0] cfg_rdata;
    logic        par_err_evt, rd_abort_evt, abort_serr_en;
    logic        mem_space_en, serr_int;

    always #2.5 clk = ~clk;

    hc_cfg_cmdstat dut (
        .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
        .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata),
        .par_err_evt(par_err_evt), .rd_abort_evt(rd_abort_evt),
        .abort_serr_en(abort_serr_en), .mem_space_en(mem_space_en),
        .serr_int(serr_int)
    );

    int unsigned errs = 0, checks = 0;
    bit          done = 0;
    logic [15:0] m_cmd, m_stat;
    logic        m_serr;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] nxt_cmd(input logic [15:0] c, input logic hit,
                                            input logic [3:0] be, input logic [31:0] wd);
        logic [15:0] r = c;
        if (hit && be[0]) begin r[1] = wd[1]; r[6] = wd[6]; end
        if (hit && be[1]) r[8] = wd[8];
        return r;
    endfunction

    // one bus cycle: drive, check read path, advance, check outputs
    task automatic step(input logic [5:0] a, input logic [3:0] be, input logic [31:0] wd,
                        input logic wr, input logic par, input logic ab, input logic aen);
        logic hit, fire;
        cfg_addr = a; cfg_be = be; cfg_wdata = wd; cfg_wr = wr;
        par_err_evt = par; rd_abort_evt = ab; abort_serr_en = aen;
        #1;
        chk((a == 6'd1) ? "R11 readback" : "R12 other address",
            cfg_rdata, (a == 6'd1) ? {m_stat, m_cmd} : 32'h0);
        hit  = wr && (a == 6'd1);
        fire = m_cmd[8] & ((par & m_cmd[6]) | (ab & aen));
        m_stat[15] = par  | (m_stat[15] & ~(hit & be[3] & wd[31]));
        m_stat[14] = fire | (m_stat[14] & ~(hit & be[3] & wd[30]));
        m_cmd  = nxt_cmd(m_cmd, hit, be, wd);
        m_serr = fire;
        @(posedge clk);
        @(negedge clk);
        chk("R4 mem_space_en", {31'b0, mem_space_en}, {31'b0, m_cmd[1]});
        chk("R6/R7 serr_int", {31'b0, serr_int}, {31'b0, m_serr});
    endtask

    task automatic rd_dir(input string req, input logic [31:0] exp);
        cfg_addr = 6'd1; cfg_wr = 1'b0; par_err_evt = 0; rd_abort_evt = 0;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; cfg_addr = 0; cfg_be = 0; cfg_wdata = 0; cfg_wr = 0;
        par_err_evt = 0; rd_abort_evt = 0; abort_serr_en = 0;
        m_cmd = 16'h0000; m_stat = 16'h0290; m_serr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1 reset values
        rd_dir("R1 reset dword", 32'h0290_0000);
        chk("R1 mem_space_en", {31'b0, mem_space_en}, 32'h0);
        chk("R1 serr_int", {31'b0, serr_int}, 32'h0);
        // R2/R3 write all ones, all lanes
        step(1, 4'hF, 32'h0000_FFFF, 1, 0, 0, 0);
        rd_dir("R2 R3 writable cmd bits", 32'h0290_0142);
        // R2 lane 1 only clears bit 8, bits 1 and 6 remain
        step(1, 4'h2, 32'h0000_0000, 1, 0, 0, 0);
        rd_dir("R2 lane select", 32'h0290_0042);
        step(1, 4'h3, 32'h0000_0141, 1, 0, 0, 0);
        rd_dir("R3 bit0 ignored", 32'h0290_0140);
        // R5/R6/R8 parity with response and enable on
        step(1, 4'h0, 32'h0, 0, 1, 0, 0);
        chk("R6 pulse", {31'b0, serr_int}, 32'h1);
        rd_dir("R5 R8 flags set", 32'hC290_0140);
        step(1, 4'h0, 32'h0, 0, 0, 0, 0);
        chk("R6 single cycle", {31'b0, serr_int}, 32'h0);
        // R9 clear only system-error flag; zero leaves parity flag
        step(1, 4'h8, 32'h4000_0000, 1, 0, 0, 0);
        rd_dir("R9 w1c", 32'h8290_0140);
        // R9 byte enable 3 off: no clear
        step(1, 4'h7, 32'hC000_0140, 1, 0, 0, 0);
        rd_dir("R9 lane off", 32'h8290_0140);
        // R10 set wins over clear
        step(1, 4'h8, 32'h8000_0000, 1, 1, 0, 0);
        rd_dir("R10 set wins", 32'hC290_0140);
        // R7 abort path
        step(1, 4'h8, 32'hC000_0000, 1, 0, 0, 0);
        step(1, 4'h0, 32'h0, 0, 0, 1, 1);
        chk("R7 abort pulse", {31'b0, serr_int}, 32'h1);
        // R8 enable off: no system error
        step(1, 4'h3, 32'h0000_0042, 1, 0, 0, 0);
        step(1, 4'h8, 32'hC000_0000, 1, 0, 0, 0);
        step(1, 4'h0, 32'h0, 0, 1, 1, 1);
        chk("R8 gated pulse", {31'b0, serr_int}, 32'h0);
        rd_dir("R8 gated flag", 32'h8290_0042);
        // R11 writes to read-only status bits ignored
        step(1, 4'hC, 32'h3FFF_0000, 1, 0, 0, 0);
        rd_dir("R11 ro status", 32'h8290_0042);
        // R12 other address write ignored
        step(2, 4'hF, 32'hFFFF_FFFF, 1, 0, 0, 0);
        rd_dir("R12 no effect", 32'h8290_0042);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [5:0] a;
            a = ($urandom % 4 == 0) ? 6'($urandom) : 6'd1;
            step(a, 4'($urandom), $urandom, ($urandom % 2) == 0,
                 ($urandom % 4) == 0, ($urandom % 4) == 0, ($urandom % 2) == 0);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule